// File: doc/BRIEF.md
# Program Counter with Branch Target

This block keeps the instruction address of a single-cycle 64-bit processor and drives it to instruction fetch. On every rising clock edge it loads one of two values: the sequential address, or a branch target. The sequential address is the current address plus the 4-byte instruction size. The branch target is that sequential address plus the instruction's 16-bit immediate, sign-extended and scaled by four. Both sums come from adders inside the block. The processor ALU is not used for them.

The decode stage marks the current instruction as a branch-on-not-equal, a branch-on-equal, or neither. The ALU supplies its zero flag from subtracting the two compared registers. All inputs are plain control and data pins sampled at the clock edge. No handshake is involved, because a new address is produced every cycle and nothing can stall it.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is loaded with 0, whatever the other inputs are.
- R2: When no branch is taken, the next address equals the current address plus 4.
- R3: The immediate is read as a 16-bit two's-complement value. Bit 15 is the sign, and it fills bits 63:16 of the extended value (0xb123 counts as -20189).
- R4: A taken branch loads (current address + 4) + (sign-extended immediate × 4). The effective byte offset is 18 bits, in the range -131072 to +131068.
- R5: With `br_ne_i` high, the branch is taken when `zero_i` is 0 and not taken when `zero_i` is 1.
- R6: With `br_eq_i` high, the branch is taken when `zero_i` is 1 and not taken when `zero_i` is 0.
- R7: With both branch inputs low, `zero_i` and `imm_i` have no effect, and the address advances by 4.
- R8: With both branch inputs high, the branch is taken whatever `zero_i` is.
- R9: All sums wrap modulo 2^64. A backward offset from a low address lands near the top of the space, and a forward offset past the top lands near 0.
- R10: Bits 1:0 of `fetch_addr_o` are always 0.
- R11: `fetch_addr_o` changes only at a rising clock edge. Input changes between edges do not show on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imm_i | input | 16 | Immediate field of the current instruction, two's complement |
| br_ne_i | input | 1 | Current instruction branches when the compared registers differ |
| br_eq_i | input | 1 | Current instruction branches when the compared registers match |
| zero_i | input | 1 | ALU zero flag from subtracting the two compared registers |
| fetch_addr_o | output | 64 | Current program counter, used as the instruction fetch address |

## Verification
The block's only state is the address register, and that register is the output, so a wrong internal value shows on `fetch_addr_o` no later than the sample taken after the edge that loaded it. A fault in the offset path stays hidden until a branch is actually taken. The bench therefore takes branches in both polarities, with positive, negative and extreme immediates. A fault in the taken decision shows as a jump on a cycle that should be sequential, or the reverse. To catch these, every combination of the branch inputs and the zero flag is driven, and a reference model is compared with the output on every cycle.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
  typedef enum logic {
    SEL_SEQ = 1'b0,
    SEL_TGT = 1'b1
  } next_sel_e;
endpackage

// File: rtl/pc_seq_adder.sv
module pc_seq_adder #(
  parameter int ADDR_W     = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] seq_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  // Fixed-increment adder; the carry out of the top bit is dropped (R9 wrap)
  assign seq_o = pc_i + STEP;
endmodule

// File: rtl/pc_offset_gen.sv
module pc_offset_gen #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 16,
  parameter int SHIFT  = 2
) (
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] off_o
);
  localparam int FILL_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] ext_w;

  // Two's-complement widening, then word scaling
  assign ext_w = {{FILL_W{imm_i[IMM_W-1]}}, imm_i};
  assign off_o = ext_w << SHIFT;

  always_comb begin
    if (!$isunknown(imm_i)) begin
      p_sign_top_r3: assert (off_o[ADDR_W-1] == imm_i[IMM_W-1])
        else $error("offset sign bit lost");
      p_field_kept_r4: assert (off_o[SHIFT+IMM_W-2:SHIFT] == imm_i[IMM_W-2:0])
        else $error("offset field misplaced");
    end
  end

  generate
    if (SHIFT > 0) begin : g_low_zero
      always_comb begin
        if (!$isunknown(imm_i)) begin
          p_off_aligned_r10: assert (off_o[SHIFT-1:0] == '0)
            else $error("offset not aligned");
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pc_target_adder.sv
module pc_target_adder #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic [ADDR_W-1:0] tgt_o
);
  // Dedicated branch-target adder, independent of the ALU
  assign tgt_o = seq_i + off_i;
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int          ADDR_W     = 64,
  parameter int          IMM_W      = 16,
  parameter int          INSN_BYTES = 4,
  parameter logic [63:0] RESET_ADDR = 64'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              br_ne_i,
  input  logic              br_eq_i,
  input  logic              zero_i,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  import pc_unit_pkg::*;

  localparam int SHIFT = $clog2(INSN_BYTES);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] seq_w;
  logic [ADDR_W-1:0] off_w;
  logic [ADDR_W-1:0] tgt_w;
  logic [ADDR_W-1:0] next_w;
  next_sel_e         sel_w;

  pc_seq_adder #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_seq (
    .pc_i  (pc_q),
    .seq_o (seq_w)
  );

  pc_offset_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_off (
    .imm_i (imm_i),
    .off_o (off_w)
  );

  pc_target_adder #(.ADDR_W(ADDR_W)) u_tgt (
    .seq_i (seq_w),
    .off_i (off_w),
    .tgt_o (tgt_w)
  );

  // Taken: not-equal branch with zero low, or equal branch with zero high
  always_comb begin
    sel_w = SEL_SEQ;
    if ((br_ne_i && !zero_i) || (br_eq_i && zero_i)) sel_w = SEL_TGT;
  end

  assign next_w = (sel_w == SEL_TGT) ? tgt_w : seq_w;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_ADDR[ADDR_W-1:0];
    else     pc_q <= next_w;
  end

  assign fetch_addr_o = pc_q;

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_w == SEL_SEQ) |=> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(INSN_BYTES)))
    else $error("sequential step wrong");

  p_target_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_w == SEL_TGT) |=> (fetch_addr_o == $past(seq_w) + $past(off_w)))
    else $error("branch target wrong");

  p_idle_seq_r7: assert property (@(posedge clk) disable iff (rst)
    (!br_ne_i && !br_eq_i) |-> (sel_w == SEL_SEQ))
    else $error("branch taken with no branch");

  p_both_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (br_ne_i && br_eq_i) |-> (sel_w == SEL_TGT))
    else $error("dual branch not taken");

  p_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fetch_addr_o[SHIFT-1:0] == '0))
    else $error("fetch address misaligned");
endmodule

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imm_i = '0;
  logic        br_ne_i = 1'b0;
  logic        br_eq_i = 1'b0;
  logic        zero_i = 1'b0;
  logic [63:0] fetch_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] model_pc = '0;

  always #2 clk = ~clk;

  pc_next_unit u_pc_next_unit (
    .clk          (clk),
    .rst          (rst),
    .imm_i        (imm_i),
    .br_ne_i      (br_ne_i),
    .br_eq_i      (br_eq_i),
    .zero_i       (zero_i),
    .fetch_addr_o (fetch_addr_o)
  );

  function automatic logic [63:0] scaled(input logic [15:0] imm);
    longint s;
    s = longint'($signed(imm)) * 4;
    return 64'(s);
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a falling edge: drive, check no leakage, clock, check result
  task automatic step(input logic r, input logic [15:0] imm, input logic ne,
                      input logic eq, input logic z, input string req);
    bit taken;
    rst = r; imm_i = imm; br_ne_i = ne; br_eq_i = eq; zero_i = z;
    #1;
    check("R11", fetch_addr_o, model_pc);
    @(posedge clk);
    taken = (ne && !z) || (eq && z);
    if (r) model_pc = 64'h0;
    else if (taken) model_pc = model_pc + 64'd4 + scaled(imm);
    else model_pc = model_pc + 64'd4;
    @(negedge clk);
    check(req, fetch_addr_o, model_pc);
    check("R10", {62'h0, fetch_addr_o[1:0]}, 64'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    // R1: reset wins over a would-be branch
    step(1'b1, 16'h0100, 1'b1, 1'b1, 1'b0, "R1");
    step(1'b1, 16'h7fff, 1'b1, 1'b0, 1'b0, "R1");
    // R2 / R7: sequential with no branch, noise on zero and imm
    step(1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b0, 16'hffff, 1'b0, 1'b0, 1'b1, "R7");
    step(1'b0, 16'h8000, 1'b0, 1'b0, 1'b0, "R7");
    // R5: not-equal branch both ways
    step(1'b0, 16'h0010, 1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 16'h0010, 1'b1, 1'b0, 1'b1, "R5");
    // R6: equal branch both ways
    step(1'b0, 16'h0020, 1'b0, 1'b1, 1'b1, "R6");
    step(1'b0, 16'h0020, 1'b0, 1'b1, 1'b0, "R6");
    // R8: both high, zero either way
    step(1'b0, 16'h0003, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b0, 16'h0003, 1'b1, 1'b1, 1'b1, "R8");
    // R3: negative immediate 0xb123 (-20189 words)
    step(1'b0, 16'hb123, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, 16'h4f00, 1'b1, 1'b0, 1'b0, "R3");
    // R4: extreme positive offset
    step(1'b0, 16'h7fff, 1'b0, 1'b1, 1'b1, "R4");
    // R9: back to 0, then below 0, then forward past the top
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b0, 16'hffff, 1'b1, 1'b0, 1'b0, "R9");
    check("R9", fetch_addr_o, 64'h0);
    step(1'b0, 16'h8000, 1'b1, 1'b0, 1'b0, "R9");
    check("R9", fetch_addr_o, 64'hffff_ffff_fffe_0004);
    step(1'b0, 16'h7fff, 1'b0, 1'b1, 1'b1, "R9");
    check("R9", fetch_addr_o, 64'h0000_0000_0000_0004);
    // Mixed sweep, deterministic LFSR stimulus
    lf = 16'hace1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(i % 97 == 50, lf, lf[3], lf[7], lf[11], "R4");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule